// File: doc/BRIEF.md
# Conditional Relative Branch Resolver

This block settles conditional relative branches for an 8-bit processor with a 16-bit program counter. A one-cycle `start` strobe presents the opcode byte, the signed displacement byte, the negative, overflow, carry and zero status flags, and the program counter. That program counter already points past the two-byte instruction. The block decides whether the opcode is a branch. It picks the flag to test and the polarity that flag must have, and it works out the destination.

It also reports how many cycles the instruction costs. A branch that falls through costs two cycles and a branch that is taken costs three. A taken branch whose destination lands in a different 256-byte page costs four. All results are registered. They appear one clock after `start`, together with a one-cycle `done` pulse, and they hold until the next strobe. The sequencer around the block fetches the operands, loads the new program counter and counts down the reported cycles.

Top module: `branch_resolver`

## Requirements
- R1: An opcode is a branch exactly when its bits 4:0 equal 5'b10000; `is_branch` reports this.
- R2: Opcode bits 7:6 choose the flag under test: 0 negative, 1 overflow, 2 carry, 3 zero. The other three flags have no effect on the decision.
- R3: A branch is taken exactly when the chosen flag equals opcode bit 5.
- R4: For a taken branch, `next_pc` equals `pc_in` plus the displacement sign-extended to 16 bits, modulo 2^16.
- R5: A branch that is not taken yields `next_pc` equal to `pc_in` and `cycles` equal to 2.
- R6: A taken branch whose destination has the same upper byte as `pc_in` yields `cycles` equal to 3.
- R7: A taken branch whose destination upper byte differs from that of `pc_in` yields `cycles` equal to 4, including a wrap past 16'hFFFF.
- R8: `done` is high for exactly the cycle after a `start` cycle. Without `start`, the outputs hold their previous values.
- R9: A non-branch opcode gives `is_branch` = 0 and `taken` = 0.
- R10: After reset, `done`, `is_branch`, `taken`, `next_pc` and `cycles` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Strobe that samples the request inputs |
| opcode | input | 8 | Instruction opcode byte |
| disp | input | 8 | Two's-complement displacement |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| pc_in | input | 16 | Program counter past the two-byte instruction |
| done | output | 1 | Result valid pulse, one clock after start |
| is_branch | output | 1 | Opcode is a conditional branch |
| taken | output | 1 | Branch condition satisfied |
| next_pc | output | 16 | Destination if taken, otherwise pc_in |
| cycles | output | 3 | Cycle cost of the instruction |

## Verification
Every result is registered, so a fault in the decode or in the addition appears at the ports in the single cycle where `done` is high. In that cycle a wrong flag choice or an inverted polarity shows as a wrong `taken` bit. A sign-extension fault shows only on backward displacements, as a `next_pc` 256 too high. A faulty page comparison shows as a cycle count of 3 where 4 is due, or 4 where 3 is due. The stimulus therefore covers every flag with both polarities, forward and backward page crossings and the wrap past the top of the address space. It also checks that the held state does not drift between strobes.

// File: rtl/br_pkg.sv
package br_pkg;
    localparam int BR_PC_W   = 16;
    localparam int BR_DISP_W = 8;
    localparam int BR_OP_W   = 8;
    localparam int BR_PAGE_W = 8;
    localparam int BR_CYC_W  = 3;
    localparam int BR_BASE_CYCLES = 2;

    // flag chosen by opcode bits 7:6; index into {z,c,v,n}
    typedef enum logic [1:0] {
        SEL_NEG   = 2'd0,
        SEL_OVF   = 2'd1,
        SEL_CARRY = 2'd2,
        SEL_ZERO  = 2'd3
    } flag_sel_e;
endpackage

// File: rtl/br_cond_decode.sv
module br_cond_decode
    import br_pkg::*;
#(
    parameter int OP_W = BR_OP_W
) (
    input  logic [OP_W-1:0] opcode,
    input  logic [3:0]      flags,     // {z, c, v, n}
    output logic            is_branch,
    output logic            cond_met
);
    localparam logic [4:0] BR_PATTERN = 5'b10000;

    flag_sel_e sel;
    logic      chosen;

    always_comb begin
        is_branch = (opcode[4:0] == BR_PATTERN);
        sel       = flag_sel_e'(opcode[7:6]);
        case (sel)
            SEL_NEG:   chosen = flags[0];
            SEL_OVF:   chosen = flags[1];
            SEL_CARRY: chosen = flags[2];
            default:   chosen = flags[3];
        endcase
        cond_met = is_branch && (chosen == opcode[5]);
    end
endmodule

// File: rtl/br_target_calc.sv
module br_target_calc
    import br_pkg::*;
#(
    parameter int PC_W   = BR_PC_W,
    parameter int DISP_W = BR_DISP_W,
    parameter int PAGE_W = BR_PAGE_W
) (
    input  logic [PC_W-1:0]   pc_base,
    input  logic [DISP_W-1:0] disp,
    output logic [PC_W-1:0]   target,
    output logic              page_cross
);
    localparam int EXT_W = PC_W - DISP_W;

    logic [PC_W-1:0] disp_ext;

    always_comb begin
        disp_ext   = {{EXT_W{disp[DISP_W-1]}}, disp};
        target     = pc_base + disp_ext;
        page_cross = (target[PC_W-1:PAGE_W] != pc_base[PC_W-1:PAGE_W]);
    end
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
    import br_pkg::*;
#(
    parameter int PC_W   = BR_PC_W,
    parameter int DISP_W = BR_DISP_W,
    parameter int OP_W   = BR_OP_W,
    parameter int PAGE_W = BR_PAGE_W,
    parameter int CYC_W  = BR_CYC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OP_W-1:0]   opcode,
    input  logic [DISP_W-1:0] disp,
    input  logic              flag_n,
    input  logic              flag_v,
    input  logic              flag_c,
    input  logic              flag_z,
    input  logic [PC_W-1:0]   pc_in,
    output logic              done,
    output logic              is_branch,
    output logic              taken,
    output logic [PC_W-1:0]   next_pc,
    output logic [CYC_W-1:0]  cycles
);
    localparam logic [CYC_W-1:0] CYC_FALL  = CYC_W'(BR_BASE_CYCLES);
    localparam logic [CYC_W-1:0] CYC_TAKEN = CYC_W'(BR_BASE_CYCLES + 1);
    localparam logic [CYC_W-1:0] CYC_CROSS = CYC_W'(BR_BASE_CYCLES + 2);

    typedef struct packed {
        logic             done;
        logic             is_branch;
        logic             taken;
        logic [PC_W-1:0]  next_pc;
        logic [CYC_W-1:0] cycles;
    } res_t;

    res_t res_d, res_q;

    logic            dec_branch;
    logic            dec_met;
    logic [PC_W-1:0] calc_target;
    logic            calc_cross;

    br_cond_decode #(.OP_W(OP_W)) u_decode (
        .opcode    (opcode),
        .flags     ({flag_z, flag_c, flag_v, flag_n}),
        .is_branch (dec_branch),
        .cond_met  (dec_met)
    );

    br_target_calc #(.PC_W(PC_W), .DISP_W(DISP_W), .PAGE_W(PAGE_W)) u_target (
        .pc_base    (pc_in),
        .disp       (disp),
        .target     (calc_target),
        .page_cross (calc_cross)
    );

    always_comb begin
        res_d      = res_q;
        res_d.done = start;
        if (start) begin
            res_d.is_branch = dec_branch;
            res_d.taken     = dec_met;
            if (dec_met) begin
                res_d.next_pc = calc_target;
                res_d.cycles  = calc_cross ? CYC_CROSS : CYC_TAKEN;
            end else begin
                res_d.next_pc = pc_in;
                res_d.cycles  = CYC_FALL;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign done      = res_q.done;
    assign is_branch = res_q.is_branch;
    assign taken     = res_q.taken;
    assign next_pc   = res_q.next_pc;
    assign cycles    = res_q.cycles;
endmodule

// File: rtl/branch_resolver_chk.sv
module branch_resolver_chk #(
    parameter int PC_W  = 16,
    parameter int OP_W  = 8,
    parameter int CYC_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [OP_W-1:0]  opcode,
    input logic             done,
    input logic             is_branch,
    input logic             taken,
    input logic [PC_W-1:0]  next_pc,
    input logic [CYC_W-1:0] cycles
);
    a_r8_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (!done && $stable(next_pc) && $stable(cycles) &&
                    $stable(taken) && $stable(is_branch)));

    a_r1_branch_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (is_branch == ($past(opcode[4:0]) == 5'b10000)));

    a_r9_nonbranch_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !is_branch) |-> !taken);

    a_r5_fall_cost: assert property (@(posedge clk) disable iff (!rst_n)
        (done && is_branch && !taken) |-> (cycles == CYC_W'(2)));

    a_r6_taken_cost: assert property (@(posedge clk) disable iff (!rst_n)
        (done && taken) |-> (cycles == CYC_W'(3) || cycles == CYC_W'(4)));
endmodule

bind branch_resolver branch_resolver_chk #(
    .PC_W(PC_W), .OP_W(OP_W), .CYC_W(CYC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .opcode    (opcode),
    .done      (done),
    .is_branch (is_branch),
    .taken     (taken),
    .next_pc   (next_pc),
    .cycles    (cycles)
);

// File: tb/tb_branch_resolver.sv
module tb_branch_resolver;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = '0;
    logic [7:0]  disp = '0;
    logic        flag_n = 1'b0, flag_v = 1'b0, flag_c = 1'b0, flag_z = 1'b0;
    logic [15:0] pc_in = '0;
    logic        done, is_branch, taken;
    logic [15:0] next_pc;
    logic [2:0]  cycles;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        string       tag;
        logic        br;
        logic        tk;
        logic [15:0] pc;
        logic [2:0]  cyc;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;   // 125 MHz

    branch_resolver dut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .disp(disp),
        .flag_n(flag_n), .flag_v(flag_v), .flag_c(flag_c), .flag_z(flag_z),
        .pc_in(pc_in), .done(done), .is_branch(is_branch), .taken(taken),
        .next_pc(next_pc), .cycles(cycles)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: apply one request and push what the requirements predict.
    task automatic drive(input string tag, input logic [7:0] op, input logic [7:0] d,
                         input logic [3:0] nvcz, input logic [15:0] pc);
        exp_t e;
        logic f;
        logic [15:0] tgt;
        e.tag = tag;
        e.br  = (op[4:0] == 5'b10000);
        case (op[7:6])
            2'd0: f = nvcz[3];
            2'd1: f = nvcz[2];
            2'd2: f = nvcz[1];
            default: f = nvcz[0];
        endcase
        e.tk  = e.br && (f == op[5]);
        tgt   = pc + {{8{d[7]}}, d};
        e.pc  = e.tk ? tgt : pc;
        e.cyc = !e.tk ? 3'd2 : ((tgt[15:8] != pc[15:8]) ? 3'd4 : 3'd3);
        @(negedge clk);
        opcode = op; disp = d; pc_in = pc;
        {flag_n, flag_v, flag_c, flag_z} = nvcz;
        start = 1'b1;
        sb.push_back(e);
        @(negedge clk);
        start = 1'b0;
    endtask

    // Monitor: compare every result against the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                if (sb.size() == 0) begin
                    check("R8 unexpected done", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check({e.tag, " R1 is_branch"}, 32'(is_branch), 32'(e.br));
                    check({e.tag, " R3 R9 taken"}, 32'(taken), 32'(e.tk));
                    if (e.br) begin
                        check({e.tag, " R4 R5 next_pc"}, 32'(next_pc), 32'(e.pc));
                        check({e.tag, " R5 R6 R7 cycles"}, 32'(cycles), 32'(e.cyc));
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] held_pc;
        logic [2:0]  held_cyc;
        repeat (3) @(negedge clk);
        check("R10 reset done", 32'(done), 32'd0);
        check("R10 reset is_branch", 32'(is_branch), 32'd0);
        check("R10 reset taken", 32'(taken), 32'd0);
        check("R10 reset next_pc", 32'(next_pc), 32'd0);
        check("R10 reset cycles", 32'(cycles), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // flags as {n,v,c,z}
        drive("R2 R6 neg clear taken",     8'h10, 8'h05, 4'b0000, 16'h1000);
        drive("R2 neg clear, others set",  8'h10, 8'h05, 4'b0111, 16'h1000);
        drive("R3 neg set taken back",     8'h30, 8'hFB, 4'b1000, 16'h1010);
        drive("R5 ovf set not taken",      8'h50, 8'h40, 4'b0100, 16'h2222);
        drive("R2 ovf set taken",          8'h70, 8'h02, 4'b0100, 16'h3000);
        drive("R7 carry clear fwd cross",  8'h90, 8'h20, 4'b0000, 16'h10F0);
        drive("R7 carry set back cross",   8'hB0, 8'h80, 4'b0010, 16'h2002);
        drive("R5 zero set not taken",     8'hD0, 8'h10, 4'b0001, 16'h4444);
        drive("R7 zero set wrap cross",    8'hF0, 8'h7F, 4'b0001, 16'hFFF0);
        drive("R6 zero edge same page",    8'hF0, 8'h0F, 4'b0001, 16'h12F0);
        drive("R5 carry clear polarity",   8'hB0, 8'h30, 4'b1101, 16'h5000);
        drive("R9 non-branch A9",          8'hA9, 8'h10, 4'b1111, 16'h6000);
        drive("R9 non-branch 11",          8'h11, 8'h10, 4'b0000, 16'h6000);
        drive("R9 non-branch 00",          8'h00, 8'h10, 4'b0000, 16'h6000);
        drive("R1 branch after non",       8'h90, 8'hFF, 4'b0000, 16'h0100);

        // R8: outputs hold while start stays low
        @(negedge clk);
        held_pc  = next_pc;
        held_cyc = cycles;
        opcode = 8'h10; disp = 8'h55; pc_in = 16'hABCD;
        {flag_n, flag_v, flag_c, flag_z} = 4'b0000;
        repeat (3) @(negedge clk);
        check("R8 hold done low", 32'(done), 32'd0);
        check("R8 hold next_pc", 32'(next_pc), 32'(held_pc));
        check("R8 hold cycles", 32'(cycles), 32'(held_cyc));
        check("R8 scoreboard drained", 32'(sb.size()), 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule